// File: doc/BRIEF.md
# Triple Interval Timer with 4-bit Tick Counters

This block holds a set of identical interval timers, three by default, for a small audio coprocessor. Each timer has its own free-running prescaler that divides the base clock by a per-timer ratio. When the timer is enabled, every prescaler tick advances an 8-bit divider. When the divider reaches the programmed period, it returns to zero and a 4-bit event counter steps up. Software polls the counter and treats the value as the number of periods that have passed since its last look.

The counter is visible at all times on `cnt_o`. A read strobe tells the block that software has taken the value, and the counter is then cleared. A write strobe to the counter also clears it. A target value of 0 selects the longest period, 256 ticks.

Top module: `tmr_group`

## Requirements
- R1: After reset every counter reads 0 and every target register holds 0, which selects a period of 256 ticks.
- R2: Timer i gets one prescaler tick every PRE_RATIO[i] base clock cycles, free-running from reset. The defaults are 128, 128 and 16.
- R3: With target N in 1..255 and the timer enabled, the counter steps up once every N ticks.
- R4: A target of 0 makes the counter step up once every 256 ticks.
- R5: The counter is 4 bits wide and wraps from 15 to 0.
- R6: `cnt_o` shows the current count. A cycle with `rd_i[i]` high returns that value, and from the next cycle on the counter is 0.
- R7: If a read strobe and a counter step fall in the same cycle, the read returns the value before the step and the counter then becomes 1.
- R8: A cycle with `wr_i[i]` high clears the counter, with the same timing as a read.
- R9: On a 0 to 1 change of `en_i[i]` the divider and the counter are both reset to 0. A tick in that cycle is not counted.
- R10: While `en_i[i]` is low, ticks are ignored and the counter holds its value.
- R11: A target write is used from the next divider comparison on, and it does not alter the divider. If the divider is already past the new target, it counts on and wraps at 256 before it can match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | NUM_TIMERS | Run enable, one bit per timer |
| tgt_we_i | input | NUM_TIMERS | Target write strobe, one bit per timer |
| tgt_data_i | input | 8 | Target value, shared by all timers |
| rd_i | input | NUM_TIMERS | Counter read strobe (read clears the counter) |
| wr_i | input | NUM_TIMERS | Counter write strobe (clears the counter) |
| cnt_o | output | 4*NUM_TIMERS | Counter values, timer i at bits [4i+3:4i] |

## Verification
The counter is a register, so every strobe (read, write, enable edge, target write) takes effect at the first rising edge that samples it. The bench drives strobes just after a falling edge, so the new count is visible at the next falling edge. A read returns the value shown during the strobe cycle itself. Periods are measured as whole multiples of ratio times period cycles, counted from a known divider state, so the expected counter change is exact whatever the prescaler phase. Boundary cases that need a tick in a given cycle (a read on a step, a target write at a given divider value) are placed by waiting on a behavioural model of the requirements that runs beside the block. The model is also compared against all counters at the end of each scenario.

// File: rtl/tmr_grp_pkg.sv
package tmr_grp_pkg;
  localparam int unsigned CNT_W = 4;
  localparam int unsigned DIV_W = 8;
  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [DIV_W-1:0] div_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned RATIO = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

  logic [PW-1:0] pcnt_q;

  assign tick_o = (pcnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pcnt_q <= '0;
    else         pcnt_q <= tick_o ? '0 : pcnt_q + 1'b1;
  end

  generate
    if (RATIO > 1) begin : g_gap_chk
      // R2: ticks are isolated single-cycle pulses
      p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_grp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  input  logic tgt_we_i,
  input  div_t tgt_i,
  input  logic rd_i,
  input  logic wr_i,
  output cnt_t cnt_o
);
  logic en_q;
  div_t div_q, tgt_q, div_inc, div_d;
  cnt_t cnt_q, cnt_d;
  logic rise, step, hit, clr;

  always_comb begin
    rise    = en_i & ~en_q;
    step    = en_i & ~rise & tick_i;
    div_inc = div_q + 1'b1;            // 8-bit wrap: target 0 matches after 256
    hit     = step & (div_inc == tgt_q);
    clr     = rd_i | wr_i;
    if (rise || hit) div_d = '0;
    else if (step)   div_d = div_inc;
    else             div_d = div_q;
    if (rise)     cnt_d = '0;
    else if (clr) cnt_d = cnt_t'(hit);  // read/clear wins, concurrent step lands as 1
    else          cnt_d = cnt_q + cnt_t'(hit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      div_q <= '0;
      tgt_q <= '0;
      cnt_q <= '0;
    end else begin
      en_q  <= en_i;
      div_q <= div_d;
      cnt_q <= cnt_d;
      if (tgt_we_i) tgt_q <= tgt_i;
    end
  end

  assign cnt_o = cnt_q;

  p_rise_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !en_q) |=> (cnt_q == '0 && div_q == '0));
  p_hold_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !rd_i && !wr_i) |=> ($stable(cnt_q) && $stable(div_q)));
  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i || wr_i) |=> (cnt_q <= cnt_t'(1)));
  p_single_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && en_q && !rd_i && !wr_i) |=> (cnt_t'(cnt_q - $past(cnt_q)) <= cnt_t'(1)));
  p_no_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && en_q && !tick_i) |=> $stable(div_q));
endmodule

// File: rtl/tmr_group.sv
module tmr_group
  import tmr_grp_pkg::*;
#(
  parameter int unsigned NUM_TIMERS = 3,
  parameter int unsigned PRE_RATIO [NUM_TIMERS] = '{128, 128, 16}
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_TIMERS-1:0]       en_i,
  input  logic [NUM_TIMERS-1:0]       tgt_we_i,
  input  logic [DIV_W-1:0]            tgt_data_i,
  input  logic [NUM_TIMERS-1:0]       rd_i,
  input  logic [NUM_TIMERS-1:0]       wr_i,
  output logic [NUM_TIMERS*CNT_W-1:0] cnt_o
);
  generate
    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
      logic tick;
      cnt_t cnt;

      tmr_prescaler #(.RATIO(PRE_RATIO[g])) u_pre (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .tick_o(tick)
      );

      tmr_channel u_chan (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick),
        .en_i    (en_i[g]),
        .tgt_we_i(tgt_we_i[g]),
        .tgt_i   (tgt_data_i),
        .rd_i    (rd_i[g]),
        .wr_i    (wr_i[g]),
        .cnt_o   (cnt)
      );

      assign cnt_o[g*CNT_W +: CNT_W] = cnt;
    end
  endgenerate
endmodule

// File: tb/tmr_group_test.sv
`timescale 1ns/1ps
module tmr_group_test;
  localparam int N = 3;
  localparam int RAT [N] = '{128, 128, 16};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] en = '0, tgt_we = '0, rd = '0, wr = '0;
  logic [7:0] tgt_data = '0;
  logic [N*4-1:0] cnt_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  tmr_group uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tgt_we_i(tgt_we),
    .tgt_data_i(tgt_data), .rd_i(rd), .wr_i(wr), .cnt_o(cnt_o)
  );

  // behavioural model built from the requirements
  int         m_pre [N];
  logic [7:0] m_div [N];
  logic [7:0] m_tgt [N];
  logic [3:0] m_cnt [N];
  logic       m_enq [N];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_pre[i] <= 0; m_div[i] <= '0; m_tgt[i] <= '0; m_cnt[i] <= '0; m_enq[i] <= 1'b0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        logic tk, inc;
        logic [7:0] nd;
        tk  = (m_pre[i] == RAT[i] - 1);
        inc = 1'b0;
        nd  = m_div[i] + 8'd1;
        m_pre[i] <= tk ? 0 : m_pre[i] + 1;
        if (en[i] && !m_enq[i]) begin
          m_div[i] <= '0; m_cnt[i] <= '0;
        end else begin
          if (en[i] && tk) begin
            if (nd == m_tgt[i]) begin m_div[i] <= '0; inc = 1'b1; end
            else m_div[i] <= nd;
          end
          if (rd[i] || wr[i]) m_cnt[i] <= {3'b000, inc};
          else                m_cnt[i] <= m_cnt[i] + {3'b000, inc};
        end
        if (tgt_we[i]) m_tgt[i] <= tgt_data;
        m_enq[i] <= en[i];
      end
    end
  end

  function automatic logic [3:0] getc(int i);
    return cnt_o[i*4 +: 4];
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmp_model(string req);
    for (int i = 0; i < N; i++) chk(req, {4'h0, getc(i)}, {4'h0, m_cnt[i]});
  endtask

  task automatic set_tgt(int i, logic [7:0] v);
    tgt_data = v; tgt_we[i] = 1'b1; step(1); tgt_we[i] = 1'b0;
  endtask

  task automatic restart(int i);
    en[i] = 1'b0; step(1); en[i] = 1'b1; step(1);
  endtask

  task automatic t_reset;
    for (int i = 0; i < N; i++) chk("R1 reset count", {4'h0, getc(i)}, 8'd0);
  endtask

  task automatic t_period256;
    en[2] = 1'b1; step(1);
    chk("R1 fresh enable", {4'h0, getc(2)}, 8'd0);
    step(4096 * 2);
    chk("R4 period 256 from reset target", {4'h0, getc(2)}, 8'd2);
    cmp_model("R4 model");
  endtask

  task automatic t_tick_rate;
    logic [3:0] c;
    en[2] = 1'b0; set_tgt(2, 8'd1); en[2] = 1'b1; step(1);
    c = getc(2); step(16 * 10);
    chk("R2 ratio 16 target 1", {4'h0, getc(2) - c}, 8'd10);
    set_tgt(0, 8'd3); en[0] = 1'b1; step(1);
    c = getc(0); step(128 * 3 * 2);
    chk("R3 ratio 128 target 3", {4'h0, getc(0) - c}, 8'd2);
    cmp_model("R3 model");
  endtask

  task automatic t_wrap;
    logic [3:0] c;
    c = getc(2); step(16 * 17);
    chk("R5 wrap after 17 steps", {4'h0, getc(2)}, {4'h0, c + 4'd1});
    cmp_model("R5 model");
  endtask

  task automatic t_read_clear;
    logic [3:0] v, e;
    while (m_cnt[0] == 4'd0 || m_pre[0] == RAT[0] - 1) step(1);
    e = m_cnt[0];
    rd[0] = 1'b1; v = getc(0); step(1); rd[0] = 1'b0;
    chk("R6 read value", {4'h0, v}, {4'h0, e});
    chk("R6 cleared after read", {4'h0, getc(0)}, 8'd0);
  endtask

  task automatic t_read_inc;
    logic [3:0] v, e;
    while (m_cnt[2] == 4'd0 || m_pre[2] != RAT[2] - 1) step(1);
    e = m_cnt[2];
    rd[2] = 1'b1; v = getc(2); step(1); rd[2] = 1'b0;
    chk("R7 read returns pre-step value", {4'h0, v}, {4'h0, e});
    chk("R7 count is 1 after read on step", {4'h0, getc(2)}, 8'd1);
  endtask

  task automatic t_write_clear;
    while (m_cnt[0] == 4'd0 || m_pre[0] == RAT[0] - 1) step(1);
    wr[0] = 1'b1; step(1); wr[0] = 1'b0;
    chk("R8 write clears", {4'h0, getc(0)}, 8'd0);
    cmp_model("R8 model");
  endtask

  task automatic t_enable;
    logic [3:0] c;
    while (m_cnt[2] == 4'd0) step(1);
    en[2] = 1'b0; step(1);
    c = getc(2); step(100);
    chk("R10 hold while disabled", {4'h0, getc(2)}, {4'h0, c});
    en[2] = 1'b1; step(1);
    chk("R9 enable edge clears", {4'h0, getc(2)}, 8'd0);
    step(40);
    cmp_model("R9 model");
  endtask

  task automatic t_target;
    logic [3:0] c;
    en[2] = 1'b0; set_tgt(2, 8'd10); en[2] = 1'b1; step(1);
    while (m_div[2] != 8'd6 || m_pre[2] != 0) step(1);
    c = getc(2);
    tgt_data = 8'd8; tgt_we[2] = 1'b1; step(1); tgt_we[2] = 1'b0;
    step(30);
    chk("R11 no step before new target", {4'h0, getc(2)}, {4'h0, c});
    step(1);
    chk("R11 step at new target, divider kept", {4'h0, getc(2)}, {4'h0, c + 4'd1});
    while (m_div[2] != 8'd6 || m_pre[2] != 0) step(1);
    c = getc(2);
    set_tgt(2, 8'd4);
    step(16 * 40);
    chk("R11 divider past target wraps first", {4'h0, getc(2)}, {4'h0, c});
    cmp_model("R11 model");
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_period256();
    t_tick_rate();
    t_wrap();
    t_read_clear();
    t_read_inc();
    t_write_clear();
    t_enable();
    t_target();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule